// File: doc/BRIEF.md
# Service Message Endpoint

This block is the user-side end of a service network that carries short typed messages between tiles and from a host. On the receive side it accepts a message offered by the network, stores it in a small first-in first-out buffer, and tells the network it has been taken with a one-cycle consumed pulse. User logic then reads messages from the head of the buffer. Each message carries its type and its data together, and the head also shows whether the message came from the host.

On the transmit side, user logic hands over a data word and a per-tile destination bitmap. The block wraps the data into an outgoing message whose type is always the tile-core code. It holds that message until the network reports that it is available, then presents it with a single-cycle valid. A request whose bitmap selects no tile is refused and counted instead.

Top module: `svc_msg_endpoint`

## Requirements
- R1: After reset, the receive buffer is empty (`rd_valid` low), `rx_consumed`, `tx_valid` and `snd_busy` are low, and `rej_count` is zero.
- R2: When `rx_valid` is high, the buffer is not full and `rx_consumed` is low, the message is stored at that edge and `rx_consumed` is high for exactly the following cycle. `rx_consumed` is never high in two consecutive cycles.
- R3: A message is `TYPE_W + DATA_W` bits wide, with the type in the upper `TYPE_W` bits and the data in the lower `DATA_W` bits. `rd_type` and `rd_data` show the two fields of the same stored message.
- R4: `rd_from_host` is high exactly when the head type equals `HOST_CODE` (default 1). The tile-core code is `CORE_CODE` (default 2).
- R5: Messages leave the buffer in arrival order, and the buffer holds `RX_DEPTH` (default 4) messages. While it is full, no message is stored and `rx_consumed` stays low until a pop frees space.
- R6: `rd_pop` removes the head at the clock edge. A pop while the buffer is empty has no effect.
- R7: Every outgoing `tx_msg` carries `CORE_CODE` in its type field and the data given with the request in its data field. `tx_dest` bit i selects tile i, and several bits may be set.
- R8: `tx_valid` is high only in cycles where `net_avail` is high. It is high for one cycle per accepted request, and `snd_busy` is high from the edge after acceptance until the edge that ends that cycle.
- R9: While `snd_busy` is high, `tx_msg` and `tx_dest` do not change and `snd_req` is ignored.
- R10: A request with an all-zero destination bitmap is not sent. Instead `rej_count` is incremented, and it saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Network offers a message |
| rx_msg | input | TYPE_W+DATA_W | Offered message {type, data} |
| rx_consumed | output | 1 | One-cycle acknowledgement of a stored message |
| rd_pop | input | 1 | Remove the head message |
| rd_valid | output | 1 | Buffer holds at least one message |
| rd_type | output | TYPE_W | Type of the head message |
| rd_data | output | DATA_W | Data of the head message |
| rd_from_host | output | 1 | Head message came from the host |
| snd_req | input | 1 | Request to send a message |
| snd_data | input | DATA_W | Body of the message to send |
| snd_dest | input | TILES | Destination tile bitmap |
| snd_busy | output | 1 | A send is waiting for the network |
| net_avail | input | 1 | Network can take a message this cycle |
| tx_valid | output | 1 | Outgoing message valid |
| tx_msg | output | TYPE_W+DATA_W | Outgoing message {type, data} |
| tx_dest | output | TILES | Outgoing destination bitmap |
| rej_count | output | ERR_W | Saturating count of refused requests |

## Verification
The bench builds the block with `RX_DEPTH` at 4, six tiles and a 3-bit refusal counter. With the narrow counter, saturation is reached after seven refused requests. The depth of 4 lets a steady flow of offered messages fill the buffer within a few cycles. The phases of the bench cover the blocked and released acknowledgement, long stretches with the network unavailable while a send waits, pops on an empty buffer, and mixed traffic in which push, pop and send coincide.

// File: rtl/svc_msg_endpoint.sv
module svc_msg_endpoint #(
  parameter int TYPE_W    = 2,
  parameter int DATA_W    = 32,
  parameter int TILES     = 8,
  parameter int RX_DEPTH  = 4,
  parameter int ERR_W     = 8,
  parameter int HOST_CODE = 1,
  parameter int CORE_CODE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_valid,
  input  logic [TYPE_W+DATA_W-1:0] rx_msg,
  output logic                     rx_consumed,
  input  logic                     rd_pop,
  output logic                     rd_valid,
  output logic [TYPE_W-1:0]        rd_type,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_from_host,
  input  logic                     snd_req,
  input  logic [DATA_W-1:0]        snd_data,
  input  logic [TILES-1:0]         snd_dest,
  output logic                     snd_busy,
  input  logic                     net_avail,
  output logic                     tx_valid,
  output logic [TYPE_W+DATA_W-1:0] tx_msg,
  output logic [TILES-1:0]         tx_dest,
  output logic [ERR_W-1:0]         rej_count
);
  localparam int MSG_W = TYPE_W + DATA_W;
  localparam int PTR_W = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int CNT_W = $clog2(RX_DEPTH + 1);
  localparam logic [TYPE_W-1:0] HOST_T = TYPE_W'(HOST_CODE);
  localparam logic [TYPE_W-1:0] CORE_T = TYPE_W'(CORE_CODE);
  localparam logic [CNT_W-1:0]  FULL_N = CNT_W'(RX_DEPTH);
  localparam logic [PTR_W-1:0]  LAST_P = PTR_W'(RX_DEPTH - 1);

  // receive buffer
  logic [MSG_W-1:0] mem [RX_DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             full, accept, pop_ok;

  assign full     = (cnt == FULL_N);
  assign accept   = rx_valid && !full && !rx_consumed;
  assign pop_ok   = rd_pop && (cnt != '0);
  assign rd_valid = (cnt != '0);
  assign {rd_type, rd_data} = mem[rd_ptr];
  assign rd_from_host = rd_valid && (rd_type == HOST_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      cnt         <= '0;
      rx_consumed <= 1'b0;
    end else begin
      rx_consumed <= accept;
      if (accept) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
      if (pop_ok) rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(accept) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= rx_msg;
  end

  // transmit side
  logic zero_dest;
  assign zero_dest = (snd_dest == '0);
  assign tx_valid  = snd_busy && net_avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snd_busy  <= 1'b0;
      tx_msg    <= '0;
      tx_dest   <= '0;
      rej_count <= '0;
    end else if (snd_busy) begin
      if (net_avail) snd_busy <= 1'b0;
    end else if (snd_req) begin
      if (zero_dest) begin
        if (rej_count != '1) rej_count <= rej_count + 1'b1;
      end else begin
        snd_busy <= 1'b1;
        tx_msg   <= {CORE_T, snd_data};
        tx_dest  <= snd_dest;
      end
    end
  end

  // checks
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_consumed |=> !rx_consumed);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !rx_consumed);
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_N);
  p_tx_avail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> net_avail);
  p_tx_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
  p_tx_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_msg[MSG_W-1:DATA_W] == CORE_T));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_busy && !net_avail) |=> ($stable(tx_msg) && $stable(tx_dest) && snd_busy));
  p_dest_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_dest != '0));
  p_rej_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_count == '1) |=> (rej_count == '1));
endmodule

// File: tb/svc_msg_endpoint_bench.sv
module svc_msg_endpoint_bench;
  localparam int TYPE_W = 2, DATA_W = 32, TILES = 6, DEPTH = 4, ERR_W = 3;
  localparam int MSG_W = TYPE_W + DATA_W;
  localparam logic [TYPE_W-1:0] HOST_T = 2'd1, CORE_T = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rd_pop = 0, snd_req = 0, net_avail = 0;
  logic [MSG_W-1:0]  rx_msg = '0;
  logic [DATA_W-1:0] snd_data = '0;
  logic [TILES-1:0]  snd_dest = '0;
  logic rx_consumed, rd_valid, rd_from_host, snd_busy, tx_valid;
  logic [TYPE_W-1:0] rd_type;
  logic [DATA_W-1:0] rd_data;
  logic [MSG_W-1:0]  tx_msg;
  logic [TILES-1:0]  tx_dest;
  logic [ERR_W-1:0]  rej_count;

  svc_msg_endpoint #(.TYPE_W(TYPE_W), .DATA_W(DATA_W), .TILES(TILES),
    .RX_DEPTH(DEPTH), .ERR_W(ERR_W), .HOST_CODE(1), .CORE_CODE(2)) u_svc_msg_endpoint (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_msg(rx_msg),
    .rx_consumed(rx_consumed), .rd_pop(rd_pop), .rd_valid(rd_valid),
    .rd_type(rd_type), .rd_data(rd_data), .rd_from_host(rd_from_host),
    .snd_req(snd_req), .snd_data(snd_data), .snd_dest(snd_dest),
    .snd_busy(snd_busy), .net_avail(net_avail), .tx_valid(tx_valid),
    .tx_msg(tx_msg), .tx_dest(tx_dest), .rej_count(rej_count));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [MSG_W-1:0] q[$];
  bit   m_cons, m_busy;
  logic [MSG_W-1:0] m_msg;
  logic [TILES-1:0] m_dest;
  int   m_rej;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_cons = 0; m_busy = 0; m_msg = '0; m_dest = '0; m_rej = 0;
    end else begin
      bit acc;
      acc = rx_valid && !m_cons && (q.size() < DEPTH);
      if (rd_pop && q.size() > 0) void'(q.pop_front());
      if (acc) q.push_back(rx_msg);
      m_cons = acc;
      if (m_busy) begin
        if (net_avail) m_busy = 0;
      end else if (snd_req) begin
        if (snd_dest == '0) begin
          if (m_rej < (1 << ERR_W) - 1) m_rej++;
        end else begin
          m_busy = 1; m_msg = {CORE_T, snd_data}; m_dest = snd_dest;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(rx_consumed == m_cons, "R2 consumed", 64'(rx_consumed), 64'(m_cons));
    chk(rd_valid == (q.size() > 0), "R1/R5 rd_valid", 64'(rd_valid), 64'(q.size() > 0));
    if (q.size() > 0) begin
      chk({rd_type, rd_data} == q[0], "R3/R5 head message", 64'({rd_type, rd_data}), 64'(q[0]));
      chk(rd_from_host == (q[0][MSG_W-1:DATA_W] == HOST_T), "R4 from_host",
          64'(rd_from_host), 64'(q[0][MSG_W-1:DATA_W] == HOST_T));
    end
    chk(snd_busy == m_busy, "R8 busy", 64'(snd_busy), 64'(m_busy));
    chk(tx_valid == (m_busy && net_avail), "R8 tx_valid", 64'(tx_valid), 64'(m_busy && net_avail));
    if (m_busy) begin
      chk(tx_msg == m_msg, "R7/R9 tx_msg", 64'(tx_msg), 64'(m_msg));
      chk(tx_dest == m_dest, "R7/R9 tx_dest", 64'(tx_dest), 64'(m_dest));
    end
    chk(int'(rej_count) == m_rej, "R10 rej_count", 64'(rej_count), 64'(m_rej));
  endtask

  function automatic logic [MSG_W-1:0] mk_msg();
    logic [TYPE_W-1:0] t;
    t = ($urandom_range(1) == 0) ? HOST_T : CORE_T;
    return {t, 32'($urandom)};
  endfunction

  // one bench cycle: compare at negedge, then drive
  task automatic step(input int mode);
    @(negedge clk);
    compare();
    if (rx_consumed || !rx_valid) begin
      rx_msg   = mk_msg();
      rx_valid = (mode == 0) ? 1'b1 : 1'($urandom_range(3) != 0);
    end
    case (mode)
      0: begin rd_pop = 0; net_avail = 0; snd_req = 0; end
      1: begin rd_pop = 1'($urandom_range(1)); net_avail = 1'($urandom_range(1));
               snd_req = 1'($urandom_range(1)); snd_data = $urandom;
               snd_dest = ($urandom_range(4) == 0) ? '0 : TILES'($urandom); end
      2: begin rd_pop = 1; rx_valid = 0; end
      3: begin net_avail = 0; snd_req = 1; snd_data = $urandom;
               snd_dest = TILES'($urandom) | 6'b100001; end
      default: begin snd_req = 1; snd_dest = '0; net_avail = 1; end
    endcase
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!rd_valid && !rx_consumed && !tx_valid && !snd_busy && rej_count == 0,
        "R1 reset state", 64'({rd_valid, rx_consumed, tx_valid, snd_busy, rej_count}), 64'(0));
    rst_n = 1;
    repeat (30) step(0);          // R5: fill and hold while full
    repeat (10) step(2);          // R6: drain then pop on empty
    repeat (12) step(4);          // R10: zero masks to saturation
    repeat (20) step(3);          // R9: wait with network unavailable
    repeat (3000) step(1);        // mixed traffic
    snd_req = 0; rx_valid = 0;
    repeat (5) step(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule